// File: doc/BRIEF.md
# Ping-Pong Descriptor Stream Buffer Manager

This block lands an incoming byte stream in system memory through two buffers that take turns. A small descriptor store keeps, for each of the two buffers, a 32-bit start address, a 13-bit depth and three status flags: armed, filled and overrun. A page bit picks the buffer that is filling now. Each accepted byte becomes one write on a simple memory-write port. The write address is the active buffer's start address plus a running offset.

Software programs the descriptor through a write-only register port. It arms buffers by setting their armed flag and acknowledges finished ones by clearing their filled flag. When the last byte of the active buffer has been written, the block marks that buffer filled, disarms it, rewinds the offset and moves to the other buffer. If a byte arrives while the active buffer is not armed, the byte is dropped and the overrun flag of that buffer is raised. Software can then re-arm the buffer while the other one is being drained. For streaming links, each buffer's depth should be set to a whole number of frames minus one, so that frames never straddle two buffers. The depth limit depends on the channel kind chosen at build time.

Top module: `pp_desc_dma`

## Requirements
- R1: After reset all armed, filled and overrun flags, the page bit, the enable bit, the LE bit and the configuration-error flag are 0, and `mem_we_o` is 0. While the enable bit is 0, an input byte causes no memory write and changes no flag.
- R2: An accepted byte into an armed active buffer is written one clock later. `mem_we_o` is 1, `mem_addr_o` is the buffer's start address plus the offset, and `mem_data_o` is the byte. The offset starts at 0 and goes up by one per write up to the depth value inclusive, so a buffer takes depth+1 bytes.
- R3: Page bit value 0 selects the ping buffer (start register 1, depth register 3). Value 1 selects the pong buffer (start register 2, depth register 4). A write to the control register (address 0: bit 0 enable, bit 1 LE, bit 2 page) loads the page bit and rewinds the offset to 0.
- R4: The write at offset equal to depth sets that buffer's filled flag, clears its armed flag, rewinds the offset and toggles the page bit. The next byte goes to the other buffer at offset 0.
- R5: A byte accepted while the active buffer is not armed is not written and sets that buffer's overrun flag. The offset is kept, so writing resumes at the same offset once the buffer is re-armed.
- R6: A write to the flag register (address 5) acts on each bit where a 1 is written. Bits 1:0 arm ping and pong, bits 3:2 clear their filled flags, bits 5:4 clear their overrun flags, and bit 6 clears the configuration-error flag.
- R7: When the engine and software act on the same flag in the same cycle, the engine's setting of a filled or overrun flag wins over software clearing it. Software arming a buffer wins over the engine disarming it.
- R8: Depths are clamped to a limit: 8191 for stream channels and 2047 for packet channels. Writing a depth above the limit stores the limit and sets the sticky configuration-error flag `cfg_err_o`.
- R9: `le_o` follows bit 1 of the last control-register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 3 | Register address |
| cfg_wdata_i | input | 32 | Register write data |
| in_valid_i | input | 1 | Input byte valid |
| in_data_i | input | 8 | Input byte |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | 32 | Memory byte address |
| mem_data_o | output | 8 | Memory write byte |
| page_o | output | 1 | Active buffer, 0 ping, 1 pong |
| le_o | output | 1 | LE control bit |
| ready_o | output | 2 | Armed flags, bit 0 ping |
| done_o | output | 2 | Filled flags, bit 0 ping |
| err_o | output | 2 | Overrun flags, bit 0 ping |
| cfg_err_o | output | 1 | Sticky depth configuration error |

## Verification
A wrong offset or a wrong start-address choice shows on `mem_addr_o` in the cycle after the byte that exposes it. An off-by-one at the buffer end shows as the page bit and the filled flag changing one byte early or late. A wrong flag priority shows on the flag outputs in the very cycle of the collision. The clamp is checked by filling a buffer programmed with an oversized depth and watching where the page bit toggles.

// File: rtl/pp_dma_pkg.sv
package pp_dma_pkg;
  typedef enum logic {CH_STREAM = 1'b0, CH_PACKET = 1'b1} ch_kind_e;

  localparam int REG_AW = 3;
  localparam logic [REG_AW-1:0] REG_CTL    = 3'd0;
  localparam logic [REG_AW-1:0] REG_BASE0  = 3'd1;
  localparam logic [REG_AW-1:0] REG_BASE1  = 3'd2;
  localparam logic [REG_AW-1:0] REG_DEPTH0 = 3'd3;
  localparam logic [REG_AW-1:0] REG_DEPTH1 = 3'd4;
  localparam logic [REG_AW-1:0] REG_FLAGS  = 3'd5;

  localparam int CTL_EN = 0;
  localparam int CTL_LE = 1;
  localparam int CTL_PG = 2;

  localparam int FL_RDY  = 0;
  localparam int FL_DONE = 2;
  localparam int FL_ERR  = 4;
  localparam int FL_CFG  = 6;
endpackage

// File: rtl/pp_desc_table.sv
module pp_desc_table
  import pp_dma_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DEPTH_W   = 13,
  parameter int DEPTH_MAX = 8191
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   sw_we_i,
  input  logic [REG_AW-1:0]      sw_addr_i,
  input  logic [31:0]            sw_wdata_i,
  input  logic                   eng_fin_i,
  input  logic                   eng_err_i,
  output logic                   en_o,
  output logic                   le_o,
  output logic                   page_o,
  output logic                   ctl_wr_o,
  output logic [1:0][ADDR_W-1:0] base_o,
  output logic [1:0][DEPTH_W-1:0] depth_o,
  output logic [1:0]             ready_o,
  output logic [1:0]             done_o,
  output logic [1:0]             err_o,
  output logic                   cfg_err_o
);
  localparam logic [DEPTH_W-1:0] LIMIT = DEPTH_W'(DEPTH_MAX);

  logic ctl_wr, fl_wr;
  logic en_q, le_q, page_q, cfg_err_q;
  logic [1:0] ready_q, done_q, err_q, over_lim;
  logic [1:0][ADDR_W-1:0]  base_q;
  logic [1:0][DEPTH_W-1:0] depth_q;

  assign ctl_wr = sw_we_i && (sw_addr_i == REG_CTL);
  assign fl_wr  = sw_we_i && (sw_addr_i == REG_FLAGS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      le_q   <= 1'b0;
      page_q <= 1'b0;
    end else if (ctl_wr) begin
      en_q   <= sw_wdata_i[CTL_EN];
      le_q   <= sw_wdata_i[CTL_LE];
      page_q <= sw_wdata_i[CTL_PG];
    end else if (eng_fin_i) begin
      page_q <= ~page_q;
    end
  end

  for (genvar i = 0; i < 2; i++) begin : g_buf
    logic base_wr, dep_wr, hit_fin, hit_err;
    logic [DEPTH_W-1:0] dep_in;
    assign base_wr = sw_we_i && (sw_addr_i == REG_BASE0 + REG_AW'(i));
    assign dep_wr  = sw_we_i && (sw_addr_i == REG_DEPTH0 + REG_AW'(i));
    assign dep_in  = sw_wdata_i[DEPTH_W-1:0];
    assign over_lim[i] = dep_wr && (dep_in > LIMIT);
    assign hit_fin = eng_fin_i && (page_q == 1'(i));
    assign hit_err = eng_err_i && (page_q == 1'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_q[i]  <= '0;
        depth_q[i] <= '0;
        ready_q[i] <= 1'b0;
        done_q[i]  <= 1'b0;
        err_q[i]   <= 1'b0;
      end else begin
        if (base_wr) base_q[i] <= sw_wdata_i[ADDR_W-1:0];
        if (dep_wr)  depth_q[i] <= (dep_in > LIMIT) ? LIMIT : dep_in;
        // arming is newer intent than the engine's disarm
        if (fl_wr && sw_wdata_i[FL_RDY+i]) ready_q[i] <= 1'b1;
        else if (hit_fin)                  ready_q[i] <= 1'b0;
        // engine set of status beats software clear
        if (hit_fin)                            done_q[i] <= 1'b1;
        else if (fl_wr && sw_wdata_i[FL_DONE+i]) done_q[i] <= 1'b0;
        if (hit_err)                           err_q[i] <= 1'b1;
        else if (fl_wr && sw_wdata_i[FL_ERR+i]) err_q[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cfg_err_q <= 1'b0;
    else if (|over_lim)                  cfg_err_q <= 1'b1;
    else if (fl_wr && sw_wdata_i[FL_CFG]) cfg_err_q <= 1'b0;
  end

  assign en_o      = en_q;
  assign le_o      = le_q;
  assign page_o    = page_q;
  assign ctl_wr_o  = ctl_wr;
  assign base_o    = base_q;
  assign depth_o   = depth_q;
  assign ready_o   = ready_q;
  assign done_o    = done_q;
  assign err_o     = err_q;
  assign cfg_err_o = cfg_err_q;

  AST_FIN_TOGGLES_PAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_fin_i && !ctl_wr |=> page_q != $past(page_q)); // R4
  AST_FIN_SETS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_fin_i |=> done_q[$past(page_q)]); // R7
  AST_ERR_SETS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_err_i |=> err_q[$past(page_q)]); // R5
  AST_CFG_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_q && !fl_wr |=> cfg_err_q); // R8
endmodule

// File: rtl/pp_addr_engine.sv
module pp_addr_engine #(
  parameter int ADDR_W  = 32,
  parameter int DEPTH_W = 13,
  parameter int DATA_W  = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               in_valid_i,
  input  logic [DATA_W-1:0]  in_data_i,
  input  logic               en_i,
  input  logic               rdy_i,
  input  logic [ADDR_W-1:0]  base_i,
  input  logic [DEPTH_W-1:0] depth_i,
  input  logic               clr_i,
  output logic               fin_o,
  output logic               err_o,
  output logic               mem_we_o,
  output logic [ADDR_W-1:0]  mem_addr_o,
  output logic [DATA_W-1:0]  mem_data_o
);
  logic accept, go, fin;
  logic [DEPTH_W-1:0] off_q;
  logic               we_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [DATA_W-1:0]  data_q;

  assign accept = in_valid_i && en_i;
  assign go     = accept && rdy_i;
  // >= guards against a depth lowered under a running offset
  assign fin    = go && (off_q >= depth_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       off_q <= '0;
    else if (clr_i)    off_q <= '0;
    else if (fin)      off_q <= '0;
    else if (go)       off_q <= off_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      we_q <= go;
      if (go) begin
        addr_q <= base_i + ADDR_W'(off_q);
        data_q <= in_data_i;
      end
    end
  end

  assign fin_o      = fin;
  assign err_o      = accept && !rdy_i;
  assign mem_we_o   = we_q;
  assign mem_addr_o = addr_q;
  assign mem_data_o = data_q;

  AST_IDLE_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(in_valid_i && en_i) |=> !we_q); // R1
  AST_NO_WRITE_UNARMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && !rdy_i |=> !we_q); // R5
  AST_OFF_HOLD_UNARMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && !rdy_i && !clr_i |=> $stable(off_q)); // R5
  AST_OFF_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go && !fin && !clr_i |=> off_q == $past(off_q) + 1'b1); // R2
  AST_FIN_WRAPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin |=> off_q == '0); // R4
endmodule

// File: rtl/pp_desc_dma.sv
module pp_desc_dma
  import pp_dma_pkg::*;
#(
  parameter ch_kind_e CH_KIND   = CH_STREAM,
  parameter int       ADDR_W    = 32,
  parameter int       DEPTH_W   = 13,
  parameter int       PKT_DEP_W = 11,
  parameter int       DATA_W    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [2:0]        cfg_addr_i,
  input  logic [31:0]       cfg_wdata_i,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_data_o,
  output logic              page_o,
  output logic              le_o,
  output logic [1:0]        ready_o,
  output logic [1:0]        done_o,
  output logic [1:0]        err_o,
  output logic              cfg_err_o
);
  localparam int DEPTH_MAX = (CH_KIND == CH_PACKET) ? (1 << PKT_DEP_W) - 1
                                                    : (1 << DEPTH_W) - 1;

  logic en, page, ctl_wr, fin, eng_err;
  logic [1:0][ADDR_W-1:0]  base;
  logic [1:0][DEPTH_W-1:0] depth;
  logic [1:0] ready;

  pp_desc_table #(
    .ADDR_W(ADDR_W), .DEPTH_W(DEPTH_W), .DEPTH_MAX(DEPTH_MAX)
  ) u_table (
    .clk_i, .rst_ni,
    .sw_we_i(cfg_we_i), .sw_addr_i(cfg_addr_i), .sw_wdata_i(cfg_wdata_i),
    .eng_fin_i(fin), .eng_err_i(eng_err),
    .en_o(en), .le_o(le_o), .page_o(page), .ctl_wr_o(ctl_wr),
    .base_o(base), .depth_o(depth),
    .ready_o(ready), .done_o(done_o), .err_o(err_o), .cfg_err_o(cfg_err_o)
  );

  pp_addr_engine #(
    .ADDR_W(ADDR_W), .DEPTH_W(DEPTH_W), .DATA_W(DATA_W)
  ) u_engine (
    .clk_i, .rst_ni,
    .in_valid_i, .in_data_i,
    .en_i(en), .rdy_i(ready[page]), .base_i(base[page]), .depth_i(depth[page]),
    .clr_i(ctl_wr),
    .fin_o(fin), .err_o(eng_err),
    .mem_we_o, .mem_addr_o, .mem_data_o
  );

  assign page_o  = page;
  assign ready_o = ready;

  AST_DISABLED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |=> !mem_we_o); // R1
  AST_WRITE_NEEDS_ARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && en && !ready[page] |=> !mem_we_o); // R5
endmodule

// File: tb/tb_pp_desc_dma.sv
module tb_pp_desc_dma;
  import pp_dma_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic mem_we, page, le;
  logic [31:0] mem_addr;
  logic [7:0] mem_data;
  logic [1:0] ready, done, err;
  logic cfg_err;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  pp_desc_dma #(.CH_KIND(CH_PACKET)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .in_valid_i(in_valid), .in_data_i(in_data),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_data_o(mem_data),
    .page_o(page), .le_o(le), .ready_o(ready), .done_o(done), .err_o(err),
    .cfg_err_o(cfg_err)
  );

  typedef struct packed {
    logic [7:0]  d;
    logic        we;
    logic [31:0] addr;
    logic        pg;
    logic [1:0]  dn;
    logic [1:0]  er;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{8'hA1, 1'b1, 32'h1000, 1'b0, 2'b00, 2'b00},
    '{8'hA2, 1'b1, 32'h1001, 1'b0, 2'b00, 2'b00},
    '{8'hA3, 1'b1, 32'h1002, 1'b1, 2'b01, 2'b00},
    '{8'hB1, 1'b1, 32'h2000, 1'b1, 2'b01, 2'b00},
    '{8'hB2, 1'b1, 32'h2001, 1'b0, 2'b11, 2'b00},
    '{8'hC1, 1'b0, 32'h0,    1'b0, 2'b11, 2'b01},
    '{8'hC2, 1'b0, 32'h0,    1'b0, 2'b11, 2'b01}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [7:0] d,
                      input logic we, input logic [2:0] a, input logic [31:0] wd);
    in_valid = v; in_data = d; cfg_we = we; cfg_addr = a; cfg_wdata = wd;
    @(negedge clk);
    in_valid = 1'b0; cfg_we = 1'b0;
  endtask

  task automatic cfg(input logic [2:0] a, input logic [31:0] wd);
    step(1'b0, 8'h00, 1'b1, a, wd);
  endtask

  task automatic push(input logic [7:0] d);
    step(1'b1, d, 1'b0, 3'd0, 32'h0);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [1:0] rd_s, dn_s, er_s;
    repeat (2) @(negedge clk);
    check("R1 reset we", mem_we, 0);
    check("R1 reset flags", {ready, done, err, page, le, cfg_err}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    cfg(REG_BASE0, 32'h1000);
    cfg(REG_BASE1, 32'h2000);
    cfg(REG_DEPTH0, 32'd2);
    cfg(REG_DEPTH1, 32'd1);
    cfg(REG_FLAGS, 32'h3);
    check("R6 arm both", ready, 2'b11);
    cfg(REG_CTL, 32'h3);
    check("R9 le set", le, 1);
    check("R3 page ping", page, 0);

    foreach (VECS[i]) begin
      push(VECS[i].d);
      check($sformatf("R2 we v%0d", i), mem_we, VECS[i].we);
      if (VECS[i].we) begin
        check($sformatf("R2 addr v%0d", i), mem_addr, VECS[i].addr);
        check($sformatf("R2 data v%0d", i), mem_data, VECS[i].d);
      end
      check($sformatf("R4 page v%0d", i), page, VECS[i].pg);
      check($sformatf("R4 done v%0d", i), done, VECS[i].dn);
      check($sformatf("R5 err v%0d", i), err, VECS[i].er);
    end
    check("R4 ready cleared", ready, 2'b00);

    push(8'h00); // idle cycle check done via step with valid low
    step(1'b0, 8'h55, 1'b0, 3'd0, 32'h0);
    check("R1 no write when idle", mem_we, 0);

    // R5 resume at same offset after re-arm
    cfg(REG_FLAGS, 32'h11);
    check("R6 err cleared", err, 2'b00);
    push(8'hD1);
    check("R5 resume addr", mem_addr, 32'h1000);
    check("R5 resume we", mem_we, 1);

    cfg(REG_FLAGS, 32'h0C);
    check("R6 done cleared", done, 2'b00);
    push(8'hD2);
    check("R2 addr 1001", mem_addr, 32'h1001);
    // R7 collision: finish ping while software clears done0 and arms ping
    step(1'b1, 8'hD3, 1'b1, REG_FLAGS, 32'h05);
    check("R7 done wins", done[0], 1);
    check("R7 ready arm wins", ready[0], 1);
    check("R4 page after finish", page, 1);
    check("R2 last addr", mem_addr, 32'h1002);

    // R3 software page select
    cfg(REG_FLAGS, 32'h2);
    cfg(REG_CTL, 32'h5);
    check("R9 le cleared", le, 0);
    push(8'hE1);
    check("R3 pong addr", mem_addr, 32'h2000);
    cfg(REG_CTL, 32'h1);
    push(8'hE2);
    check("R3 ping rewound", mem_addr, 32'h1000);
    check("R3 page ping", page, 0);

    // R1 disabled channel ignores data
    cfg(REG_CTL, 32'h0);
    rd_s = ready; dn_s = done; er_s = err;
    push(8'hF1);
    check("R1 disabled no write", mem_we, 0);
    check("R1 disabled flags", {ready, done, err}, {rd_s, dn_s, er_s});

    // R8 clamp to packet limit 2047
    cfg(REG_DEPTH0, 32'd3000);
    check("R8 cfg err set", cfg_err, 1);
    cfg(REG_FLAGS, 32'h40);
    check("R6 cfg err cleared", cfg_err, 0);
    cfg(REG_CTL, 32'h1);
    for (int k = 0; k < 2047; k++) push(8'(k));
    check("R8 page held before limit", page, 0);
    push(8'h77);
    check("R8 clamped last addr", mem_addr, 32'h17FF);
    check("R8 toggles at limit", page, 1);

    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset again", {mem_we, ready, done, err, page, le, cfg_err}, 0);
    summary();
  end
endmodule